// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command front end of a synchronous parallel NOR flash model. The host presents each write cycle as a single-cycle strobe carrying an address and a data byte. The decoder follows the unlock-prefixed command sequences and, when one completes, raises a one-cycle request towards a separate embedded-operation engine. The requests cover program (with target address and data), sector erase (one request per queued sector address, then a start pulse), chip erase, erase suspend, erase resume and software reset.

A sector erase does not begin at once. Further sector addresses may be queued while an accumulation window is open. The window is a clock-cycle count set by a parameter, and it restarts with every sector added. When the window runs out, the decoder pulses the start request. A two-bit mode output reports whether the device is reading the array, part way through a sequence, busy, or erase-suspended. The engine reports completion on `op_done`.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After a hardware reset (`rst_n` low), including one in the middle of a sequence, `mode` is 0 (read) and all seven request pulses are low. The `mode` encoding is 0 read, 1 in sequence, 2 busy, 3 erase-suspended.
- R2: The writes 0xAA@0x555, 0x55@0x2AA, 0xA0@0x555 and then any address A with data D pulse `prog_req` for one cycle, with `op_addr`=A and `op_data`=D, and `mode` becomes 2. Only address bits [10:0] are compared. During the first three cycles `mode` is 1.
- R3: A write whose address or data does not match the current sequence step ends the sequence with no request, and `mode` returns to 0.
- R4: The writes 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA and then 0x30 at sector address S pulse `sect_req` with `op_addr`=S, and `mode` becomes 2.
- R5: While the window is open, each further write of 0x30 pulses `sect_req` with its address and restarts the window. `erase_go` pulses exactly WIN_CYC cycles after the last sector write. Any other write except 0xF0 is ignored while the window is open.
- R6: When the sixth erase cycle is 0x10@0x555 instead of a sector write, `chip_req` pulses and `mode` becomes 2.
- R7: While busy, writes other than 0xB0 and 0xF0 produce no request and leave `mode` at 2. `op_done` returns `mode` to 0.
- R8: 0xB0 written at any address while a sector erase is running pulses `susp_req` and sets `mode` to 3. During a program or a chip erase, 0xB0 is ignored.
- R9: While suspended, a write of 0x30 at any address pulses `resume_req` and sets `mode` to 2. Other writes except 0xF0 are ignored.
- R10: A write of 0xF0 at any address pulses `reset_req`. `mode` then becomes 0, or stays 3 when the decoder is suspended.
- R11: At most one request pulse is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wr_en | input | 1 | One-cycle host write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data byte |
| op_done | input | 1 | Embedded operation finished |
| prog_req | output | 1 | Program request pulse |
| sect_req | output | 1 | Sector queued for erase pulse |
| erase_go | output | 1 | Sector erase start pulse |
| chip_req | output | 1 | Chip erase request pulse |
| susp_req | output | 1 | Erase suspend request pulse |
| resume_req | output | 1 | Erase resume request pulse |
| reset_req | output | 1 | Software reset request pulse |
| op_addr | output | ADDR_W | Address for program or sector request |
| op_data | output | 8 | Data for program request |
| mode | output | 2 | 0 read, 1 in sequence, 2 busy, 3 suspended |

## Verification
The assertions assume that `op_done` is raised only while the decoder is busy and never in the same cycle as a write strobe. They also assume that each write is a single-cycle strobe. The bench respects this by spacing writes with idle cycles and by pulsing `op_done` on its own after a request has been seen. The assertions then check how `mode` moves around each request pulse and whether busy persists between events.

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int ADDR_W  = 16,
  parameter int WIN_CYC = 12500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              op_done,
  output logic              prog_req,
  output logic              sect_req,
  output logic              erase_go,
  output logic              chip_req,
  output logic              susp_req,
  output logic              resume_req,
  output logic              reset_req,
  output logic [ADDR_W-1:0] op_addr,
  output logic [7:0]        op_data,
  output logic [1:0]        mode
);
  localparam int CW = $clog2(WIN_CYC + 1);

  typedef enum logic [3:0] {
    S_RD, S_U1, S_U2, S_PSET, S_E1, S_E2, S_E3,
    S_ACC, S_PBUSY, S_CBUSY, S_EBUSY, S_SUSP
  } st_t;

  st_t st;
  logic [CW-1:0] cnt;

  wire a555  = wr_addr[10:0] == 11'h555;
  wire a2aa  = wr_addr[10:0] == 11'h2AA;
  wire d_f0  = wr_data == 8'hF0;
  wire d_30  = wr_data == 8'h30;
  wire d_b0  = wr_data == 8'hB0;
  wire k_aa  = wr_en && a555 && wr_data == 8'hAA;
  wire k_55  = wr_en && a2aa && wr_data == 8'h55;

  always_comb begin
    case (st)
      S_RD:                                mode = 2'd0;
      S_ACC, S_PBUSY, S_CBUSY, S_EBUSY:    mode = 2'd2;
      S_SUSP:                              mode = 2'd3;
      default:                             mode = 2'd1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_RD;
      cnt <= '0;
      {prog_req, sect_req, erase_go, chip_req, susp_req, resume_req, reset_req} <= '0;
      op_addr <= '0;
      op_data <= '0;
    end else begin
      {prog_req, sect_req, erase_go, chip_req, susp_req, resume_req, reset_req} <= '0;
      case (st)
        S_RD:
          if (wr_en && d_f0) reset_req <= 1'b1;
          else if (k_aa) st <= S_U1;
        S_U1, S_E1, S_E2, S_U2, S_E3:
          if (wr_en) begin
            st <= S_RD;
            if (st == S_U1 && k_55) st <= S_U2;
            else if (st == S_E1 && k_aa) st <= S_E2;
            else if (st == S_E2 && k_55) st <= S_E3;
            else if (st == S_U2 && a555 && wr_data == 8'hA0) st <= S_PSET;
            else if (st == S_U2 && a555 && wr_data == 8'h80) st <= S_E1;
            else if (st == S_E3 && d_30) begin
              st <= S_ACC;
              sect_req <= 1'b1;
              op_addr <= wr_addr;
              cnt <= '0;
            end else if (st == S_E3 && a555 && wr_data == 8'h10) begin
              st <= S_CBUSY;
              chip_req <= 1'b1;
            end else if (d_f0) reset_req <= 1'b1;
          end
        S_PSET:
          if (wr_en) begin
            st <= S_PBUSY;
            prog_req <= 1'b1;
            op_addr <= wr_addr;
            op_data <= wr_data;
          end
        S_ACC:
          if (wr_en && d_30) begin
            sect_req <= 1'b1;
            op_addr <= wr_addr;
            cnt <= '0;
          end else if (wr_en && d_f0) begin
            reset_req <= 1'b1;
            st <= S_RD;
          end else if (cnt == CW'(WIN_CYC - 1)) begin
            erase_go <= 1'b1;
            st <= S_EBUSY;
          end else cnt <= cnt + 1'b1;
        S_PBUSY, S_CBUSY, S_EBUSY:
          if (op_done) st <= S_RD;
          else if (wr_en && d_f0) begin
            reset_req <= 1'b1;
            st <= S_RD;
          end else if (wr_en && d_b0 && st == S_EBUSY) begin
            susp_req <= 1'b1;
            st <= S_SUSP;
          end
        S_SUSP:
          if (wr_en && d_f0) reset_req <= 1'b1;
          else if (wr_en && d_30) begin
            resume_req <= 1'b1;
            st <= S_EBUSY;
          end
        default: st <= S_RD;
      endcase
    end
  end

  assert_one_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_req, sect_req, erase_go, chip_req, susp_req, resume_req, reset_req}));

  assert_prog_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |-> mode == 2'd2 && $past(mode) == 2'd1);

  assert_go_from_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    erase_go |-> mode == 2'd2 && $past(mode) == 2'd2);

  assert_window_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(WIN_CYC));

  assert_busy_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode) == 2'd2 && !$past(wr_en) && !$past(op_done) |-> mode == 2'd2);

  assert_susp_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    susp_req |-> mode == 2'd3 && $past(mode) == 2'd2);

  assert_resume_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    resume_req |-> mode == 2'd2 && $past(mode) == 2'd3);

  assert_reset_dest_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> mode == 2'd0 || mode == 2'd3);
endmodule

// File: tb/sim_flash_cmd_decoder.sv
`timescale 1ns/1ps
module sim_flash_cmd_decoder;
  localparam int AW = 16;
  localparam int WIN = 20;

  logic clk = 0, rst_n = 0, wr_en = 0, op_done = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic prog_req, sect_req, erase_go, chip_req, susp_req, resume_req, reset_req;
  logic [AW-1:0] op_addr;
  logic [7:0] op_data;
  logic [1:0] mode;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  flash_cmd_decoder #(.ADDR_W(AW), .WIN_CYC(WIN)) u0 (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .op_done,
    .prog_req, .sect_req, .erase_go, .chip_req, .susp_req, .resume_req, .reset_req,
    .op_addr, .op_data, .mode);

  wire [6:0] pls = {prog_req, sect_req, erase_go, chip_req, susp_req, resume_req, reset_req};
  localparam logic [6:0] P_PROG = 7'h40, P_SECT = 7'h20, P_GO = 7'h10, P_CHIP = 7'h08,
                         P_SUSP = 7'h04, P_RES = 7'h02, P_RST = 7'h01;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic done();
    @(negedge clk); op_done = 1;
    @(negedge clk); op_done = 0;
  endtask

  task automatic unlock();
    wr(16'h0555, 8'hAA);
    wr(16'h02AA, 8'h55);
  endtask

  task automatic erase_prefix();
    unlock(); wr(16'h0555, 8'h80); unlock();
  endtask

  task automatic t_reset();
    chk("R1 mode after reset", mode, 0);
    chk("R1 pulses after reset", pls, 0);
    wr(16'h0555, 8'hAA);
    chk("R1 mode mid sequence", mode, 1);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    chk("R1 mode after mid reset", mode, 0);
    chk("R1 pulses after mid reset", pls, 0);
  endtask

  task automatic t_program();
    unlock();
    chk("R2 mode in sequence", mode, 1);
    wr(16'h0555, 8'hA0);
    chk("R2 mode after setup", mode, 1);
    wr(16'h1234, 8'h5C);
    chk("R2 prog pulse", pls, P_PROG);
    chk("R2 prog addr", op_addr, 16'h1234);
    chk("R2 prog data", op_data, 8'h5C);
    chk("R2 mode busy", mode, 2);
    @(negedge clk);
    chk("R2 single cycle", pls, 0);
    wr(16'h0555, 8'hAA);
    chk("R7 ignored in program busy", pls, 0);
    chk("R7 still busy", mode, 2);
    wr(16'h0000, 8'hB0);
    chk("R8 suspend ignored in program", pls, 0);
    chk("R8 mode after B0 in program", mode, 2);
    done();
    chk("R7 done to read", mode, 0);
  endtask

  task automatic t_abort();
    unlock(); wr(16'h0555, 8'h77);
    chk("R3 bad data pulses", pls, 0);
    chk("R3 bad data mode", mode, 0);
    wr(16'h0555, 8'hAA); wr(16'h0123, 8'h55);
    chk("R3 bad addr mode", mode, 0);
    erase_prefix(); wr(16'h0444, 8'h10);
    chk("R3 bad chip addr pulses", pls, 0);
    chk("R3 bad chip addr mode", mode, 0);
  endtask

  task automatic t_sector();
    erase_prefix();
    wr(16'h4000, 8'h30);
    chk("R4 sect pulse", pls, P_SECT);
    chk("R4 sect addr", op_addr, 16'h4000);
    chk("R4 mode busy", mode, 2);
    wr(16'h02AA, 8'h55);
    chk("R5 other write ignored in window", pls, 0);
    repeat (WIN - 3) @(negedge clk);
    chk("R5 no start before window", pls, 0);
    @(negedge clk);
    chk("R5 start at window end", pls, P_GO);
    chk("R5 mode busy after start", mode, 2);
    done();
    chk("R7 done after erase", mode, 0);
  endtask

  task automatic t_multi();
    erase_prefix();
    wr(16'h1000, 8'h30);
    repeat (5) @(negedge clk);
    wr(16'h2000, 8'h30);
    chk("R5 second sect pulse", pls, P_SECT);
    chk("R5 second sect addr", op_addr, 16'h2000);
    repeat (WIN - 1) @(negedge clk);
    chk("R5 window restarted", pls, 0);
    @(negedge clk);
    chk("R5 start after restart", pls, P_GO);
    done();
  endtask

  task automatic t_chip();
    erase_prefix();
    wr(16'h0555, 8'h10);
    chk("R6 chip pulse", pls, P_CHIP);
    chk("R6 mode busy", mode, 2);
    wr(16'h0555, 8'hAA);
    chk("R7 write ignored in chip busy", pls, 0);
    wr(16'h0000, 8'hB0);
    chk("R8 suspend ignored in chip erase", pls, 0);
    chk("R8 mode in chip erase", mode, 2);
    wr(16'h0777, 8'hF0);
    chk("R10 reset in busy pulse", pls, P_RST);
    chk("R10 reset in busy mode", mode, 0);
  endtask

  task automatic t_suspend();
    erase_prefix();
    wr(16'h8000, 8'h30);
    repeat (WIN) @(negedge clk);
    chk("R5 start before suspend", pls, P_GO);
    wr(16'h0000, 8'hB0);
    chk("R8 suspend pulse", pls, P_SUSP);
    chk("R8 mode suspended", mode, 3);
    wr(16'h0555, 8'hAA);
    chk("R9 write ignored in suspend", pls, 0);
    chk("R9 mode stays suspended", mode, 3);
    wr(16'h0001, 8'hF0);
    chk("R10 reset in suspend pulse", pls, P_RST);
    chk("R10 reset keeps suspend", mode, 3);
    wr(16'h0003, 8'h30);
    chk("R9 resume pulse", pls, P_RES);
    chk("R9 mode busy after resume", mode, 2);
    done();
    chk("R7 done after resume", mode, 0);
  endtask

  task automatic t_reset_cmd();
    wr(16'h0ABC, 8'hF0);
    chk("R10 reset in read pulse", pls, P_RST);
    chk("R10 reset in read mode", mode, 0);
    wr(16'h0555, 8'hAA);
    wr(16'h0007, 8'hF0);
    chk("R10 reset mid sequence pulse", pls, P_RST);
    chk("R10 reset mid sequence mode", mode, 0);
  endtask

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_program();
    t_abort();
    t_sector();
    t_multi();
    t_chip();
    t_suspend();
    t_reset_cmd();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule